// File: doc/BRIEF.md
# Dual Boot Region Program Lockout

This block guards the two boot regions of a 128K x 8 flash array: the lowest 8 KB and the highest 8 KB. Each region has its own lock bit. A lock bit is set by a seven-write command sequence. The first six writes must match fixed address/data pairs. The seventh write carries a lock code, and its address picks the region: an address inside the low region locks the low region, and an address inside the high region locks the high region. No command clears a lock.

Sector program requests (a 10-bit sector number, 128 bytes per sector) and whole-chip erase requests pass through the block, and it returns a one-cycle grant or reject. A program request is rejected when its sector lies in a locked region. A chip erase is rejected when either region is locked. An identification mode is entered and left through single-cycle strobes. While it is active, reads at four fixed addresses return the manufacturer code, the device code, and a status byte for each region. All command and identification codes are parameters.

Top module: `boot_lock_guard`

## Requirements
- R1: After a synchronous active-low reset, both lock outputs are 0, identification mode is inactive, and all grant and reject outputs are 0.
- R2: Six writes (0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x40) followed by a seventh write of data 0x00 to an address with bits 16..13 all zero set `lock_low`. It is visible in the cycle after the seventh write's clock edge, and `lock_high` is unchanged.
- R3: The same sequence, with the seventh address having bits 16..13 all one, sets `lock_high` independently of `lock_low`. Both may end up set.
- R4: A write that does not match the expected pair at any of the first six steps returns the recognizer to its first step without changing lock state. The remaining writes of that attempt then lock nothing.
- R5: A seventh write whose data is not 0x00, or whose address lies in neither boot region, locks nothing.
- R6: A `prog_req` raises `prog_reject` in the next cycle if its sector is 0..63 while the low region is locked, or 960..1023 while the high region is locked. Otherwise it raises `prog_grant`. Never both at once.
- R7: An `erase_req` raises `erase_reject` in the next cycle if either region is locked, and `erase_grant` otherwise.
- R8: `id_enter` starts identification mode from the next cycle and `id_exit` ends it, with exit winning when both are pulsed together. While the mode is active, read address 0x00000 gives 0x1F and 0x00001 gives 0x5D. While it is inactive, `id_data` is 0x00 and `id_hit` is 0.
- R9: In identification mode, read address 0x00002 gives the low-region status and 0x1FFF2 the high-region status: 0xFE when unlocked, 0xFF when locked. Any other address gives 0x00 with `id_hit` low.
- R10: Once set, a lock bit stays set through later writes, command sequences and identification strobes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One write-command event this cycle |
| wr_addr | input | 17 | Byte address of the write command |
| wr_data | input | 8 | Data of the write command |
| prog_req | input | 1 | Sector program request |
| prog_sector | input | 10 | Sector number of the program request |
| prog_grant | output | 1 | Program allowed (registered) |
| prog_reject | output | 1 | Program vetoed (registered) |
| erase_req | input | 1 | Whole-chip erase request |
| erase_grant | output | 1 | Chip erase allowed (registered) |
| erase_reject | output | 1 | Chip erase vetoed (registered) |
| id_enter | input | 1 | Strobe entering identification mode |
| id_exit | input | 1 | Strobe leaving identification mode |
| rd_addr | input | 17 | Read address for identification data |
| id_active | output | 1 | Identification mode is active |
| id_hit | output | 1 | rd_addr is one of the four identification addresses |
| id_data | output | 8 | Identification or status byte |
| lock_low | output | 1 | Low 8 KB region locked |
| lock_high | output | 1 | High 8 KB region locked |

## Verification
The bench probes the region boundaries (sectors 63/64 and 959/960). A design that derived the region from the wrong address bits would grant a program into a locked region or reject one just outside it. It breaks an attempt at step four and then completes the rest: a recognizer that only restarts its count, or ignores mismatches, would lock here when it should not. It sends a final write with bad data and one with a final address in the middle of the array, to catch a recognizer that does not check the seventh write. It locks the regions one at a time and reads both status bytes after each lock, which exposes swapped or shared lock bits. It pulses enter and exit together to pin down the priority between the two strobes.

// File: rtl/boot_lock_pkg.sv
// Shared definitions for the boot-region lockout logic.
// Assumes exactly two protected regions: index 0 low, index 1 high.
package boot_lock_pkg;
    localparam int NUM_REGIONS = 2;
    localparam int REGION_LOW  = 0;
    localparam int REGION_HIGH = 1;

    typedef logic [NUM_REGIONS-1:0] region_vec_t;
endpackage

// File: rtl/lock_seq_recognizer.sv
// Recognizes the lock command sequence: STEPS fixed address/data writes,
// then a final write of LOCK_DATA whose address selects the region.
// Assumes at most one write event per cycle. Any mismatch returns to step 0.
// The set request is combinational, so the lock is taken on the same edge
// that samples the final write.
module lock_seq_recognizer
    import boot_lock_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int STEPS   = 6,
    parameter int BOOT_AW = 13,
    parameter logic [STEPS*ADDR_W-1:0] SEQ_ADDR = '0,
    parameter logic [STEPS*DATA_W-1:0] SEQ_DATA = '0,
    parameter logic [DATA_W-1:0] LOCK_DATA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output region_vec_t       set_req
);
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int TOP_W = ADDR_W - BOOT_AW;

    logic [CNT_W-1:0]  step_q;
    logic              at_final;
    logic              pair_ok;
    logic              hit_low;
    logic              hit_high;
    logic [ADDR_W-1:0] exp_addr;
    logic [DATA_W-1:0] exp_data;
    int                idx;

    // Look up the expected pair for the current step and classify the address.
    always_comb begin
        at_final = (step_q == CNT_W'(STEPS));
        idx      = at_final ? 0 : int'(step_q);
        exp_addr = SEQ_ADDR[idx*ADDR_W +: ADDR_W];
        exp_data = SEQ_DATA[idx*DATA_W +: DATA_W];
        pair_ok  = (wr_addr == exp_addr) && (wr_data == exp_data);
        hit_low  = (wr_addr[ADDR_W-1 -: TOP_W] == '0);
        hit_high = (&wr_addr[ADDR_W-1 -: TOP_W]);
        set_req  = '0;
        set_req[REGION_LOW]  = wr_valid && at_final && (wr_data == LOCK_DATA) && hit_low;
        set_req[REGION_HIGH] = wr_valid && at_final && (wr_data == LOCK_DATA) && hit_high;
    end

    // Advance on a matching write; fall back to step 0 on mismatch or after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (wr_valid) begin
            if (at_final || !pair_ok) begin
                step_q <= '0;
            end else begin
                step_q <= step_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/region_lock_cell.sv
// One sticky lock bit. Only reset clears it; a set request sets it.
// Assumes set requests are single-cycle and may repeat harmlessly.
module region_lock_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic locked_o
);
    // Hold the lock once set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
        end else if (set_i) begin
            locked_o <= 1'b1;
        end
    end
endmodule

// File: rtl/lock_veto.sv
// Decides program and chip-erase requests against the current lock state.
// Answers are registered: one cycle after the request, exactly one of
// grant/reject is high for each request type that was asserted.
module lock_veto
    import boot_lock_pkg::*;
#(
    parameter int SECT_W = 10,
    parameter int TOP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [SECT_W-1:0] prog_sector,
    input  logic              erase_req,
    input  region_vec_t       locked,
    output logic              prog_grant,
    output logic              prog_reject,
    output logic              erase_grant,
    output logic              erase_reject
);
    logic in_low;
    logic in_high;
    logic prog_block;
    logic erase_block;

    // Map the sector onto a region and combine with the lock bits.
    always_comb begin
        in_low      = (prog_sector[SECT_W-1 -: TOP_W] == '0);
        in_high     = (&prog_sector[SECT_W-1 -: TOP_W]);
        prog_block  = (in_low && locked[REGION_LOW]) || (in_high && locked[REGION_HIGH]);
        erase_block = |locked;
    end

    // Register the verdicts for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_grant   <= 1'b0;
            prog_reject  <= 1'b0;
            erase_grant  <= 1'b0;
            erase_reject <= 1'b0;
        end else begin
            prog_grant   <= prog_req && !prog_block;
            prog_reject  <= prog_req && prog_block;
            erase_grant  <= erase_req && !erase_block;
            erase_reject <= erase_req && erase_block;
        end
    end
endmodule

// File: rtl/id_readout.sv
// Identification mode flag and read decode of the four fixed addresses.
// Assumes enter/exit are single-cycle strobes; exit wins when both arrive.
// The read path is combinational from rd_addr.
module id_readout
    import boot_lock_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] MFR_ADDR  = 17'h00000,
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 17'h00001,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 17'h00002,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 17'h1FFF2,
    parameter logic [DATA_W-1:0] MFR_CODE  = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_CODE  = 8'h5D,
    parameter logic [DATA_W-1:0] STAT_OPEN = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_enter,
    input  logic              id_exit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  region_vec_t       locked,
    output logic              id_active,
    output logic              id_hit,
    output logic [DATA_W-1:0] id_data
);
    // Track the mode flag from the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_active <= 1'b0;
        end else if (id_exit) begin
            id_active <= 1'b0;
        end else if (id_enter) begin
            id_active <= 1'b1;
        end
    end

    // Decode the read address into a code or status byte.
    always_comb begin
        id_hit  = 1'b0;
        id_data = '0;
        if (id_active) begin
            if (rd_addr == MFR_ADDR) begin
                id_hit  = 1'b1;
                id_data = MFR_CODE;
            end else if (rd_addr == DEV_ADDR) begin
                id_hit  = 1'b1;
                id_data = DEV_CODE;
            end else if (rd_addr == LOW_ADDR) begin
                id_hit  = 1'b1;
                id_data = STAT_OPEN | DATA_W'(locked[REGION_LOW]);
            end else if (rd_addr == HIGH_ADDR) begin
                id_hit  = 1'b1;
                id_data = STAT_OPEN | DATA_W'(locked[REGION_HIGH]);
            end
        end
    end
endmodule

// File: rtl/boot_lock_guard.sv
// Top of the dual boot-region lockout. It ties together the command
// recognizer, one lock cell per region, the request veto and the
// identification readout.
// Assumes the array is 2^ADDR_W bytes of SECTOR_BYTES-byte sectors and that
// each boot region spans BOOT_BYTES at either end of the array.
module boot_lock_guard
    import boot_lock_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 128,
    parameter int BOOT_BYTES   = 8192,
    parameter int SEQ_STEPS    = 6,
    parameter logic [SEQ_STEPS*ADDR_W-1:0] SEQ_ADDR =
        {17'h05555, 17'h02AAA, 17'h05555, 17'h05555, 17'h02AAA, 17'h05555},
    parameter logic [SEQ_STEPS*DATA_W-1:0] SEQ_DATA =
        {8'h40, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA},
    parameter logic [DATA_W-1:0] LOCK_DATA = 8'h00,
    parameter logic [DATA_W-1:0] MFR_CODE  = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_CODE  = 8'h5D,
    parameter int SECT_W = ADDR_W - $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_req,
    input  logic [SECT_W-1:0] prog_sector,
    output logic              prog_grant,
    output logic              prog_reject,
    input  logic              erase_req,
    output logic              erase_grant,
    output logic              erase_reject,
    input  logic              id_enter,
    input  logic              id_exit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_active,
    output logic              id_hit,
    output logic [DATA_W-1:0] id_data,
    output logic              lock_low,
    output logic              lock_high
);
    localparam int BOOT_AW = $clog2(BOOT_BYTES);
    localparam int TOP_W   = ADDR_W - BOOT_AW;

    region_vec_t set_req;
    region_vec_t locked;

    lock_seq_recognizer #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STEPS    (SEQ_STEPS),
        .BOOT_AW  (BOOT_AW),
        .SEQ_ADDR (SEQ_ADDR),
        .SEQ_DATA (SEQ_DATA),
        .LOCK_DATA(LOCK_DATA)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_req (set_req)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        region_lock_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_req[r]),
            .locked_o(locked[r])
        );
    end

    lock_veto #(
        .SECT_W(SECT_W),
        .TOP_W (TOP_W)
    ) u_veto (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_req    (prog_req),
        .prog_sector (prog_sector),
        .erase_req   (erase_req),
        .locked      (locked),
        .prog_grant  (prog_grant),
        .prog_reject (prog_reject),
        .erase_grant (erase_grant),
        .erase_reject(erase_reject)
    );

    id_readout #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MFR_CODE(MFR_CODE),
        .DEV_CODE(DEV_CODE)
    ) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_enter (id_enter),
        .id_exit  (id_exit),
        .rd_addr  (rd_addr),
        .locked   (locked),
        .id_active(id_active),
        .id_hit   (id_hit),
        .id_data  (id_data)
    );

    // Expose the lock bits.
    always_comb begin
        lock_low  = locked[REGION_LOW];
        lock_high = locked[REGION_HIGH];
    end
endmodule

// File: rtl/boot_lock_guard_checker.sv
// Temporal checks on the lockout top, attached through bind.
// Assumes the default geometry: 1024 sectors, 64 per boot region.
module boot_lock_guard_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       prog_req,
    input logic [9:0] prog_sector,
    input logic       prog_grant,
    input logic       prog_reject,
    input logic       erase_req,
    input logic       erase_grant,
    input logic       erase_reject,
    input logic       id_active,
    input logic [7:0] id_data,
    input logic       lock_low,
    input logic       lock_high
);
    AST_LOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_low |=> lock_low); // R10
    AST_HIGH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_high |=> lock_high); // R10
    AST_LOCK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_low) || $rose(lock_high)) |-> $past(wr_valid)); // R2
    AST_LOW_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && lock_low && prog_sector < 10'd64) |=> prog_reject); // R6
    AST_HIGH_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && lock_high && prog_sector >= 10'd960) |=> prog_reject); // R6
    AST_PROG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_grant && prog_reject)); // R6
    AST_ERASE_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && (lock_low || lock_high)) |=> (erase_reject && !erase_grant)); // R7
    AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !id_active |-> (id_data == 8'h00)); // R8
endmodule

bind boot_lock_guard boot_lock_guard_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .prog_req    (prog_req),
    .prog_sector (prog_sector),
    .prog_grant  (prog_grant),
    .prog_reject (prog_reject),
    .erase_req   (erase_req),
    .erase_grant (erase_grant),
    .erase_reject(erase_reject),
    .id_active   (id_active),
    .id_data     (id_data),
    .lock_low    (lock_low),
    .lock_high   (lock_high)
);

// File: tb/boot_lock_guard_bench.sv
module boot_lock_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_req = 1'b0;
    logic [9:0]  prog_sector = '0;
    logic        prog_grant, prog_reject;
    logic        erase_req = 1'b0;
    logic        erase_grant, erase_reject;
    logic        id_enter = 1'b0;
    logic        id_exit = 1'b0;
    logic [16:0] rd_addr = '0;
    logic        id_active, id_hit;
    logic [7:0]  id_data;
    logic        lock_low, lock_high;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    boot_lock_guard u_boot_lock_guard (.*);

    // Command pairs of the lock sequence, step 0 first.
    localparam logic [16:0] S_ADDR [6] = '{17'h05555, 17'h02AAA, 17'h05555,
                                           17'h05555, 17'h02AAA, 17'h05555};
    localparam logic [7:0]  S_DATA [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h40};

    // Vector table, with only the low region locked: {kind, addr/sector, expected}.
    // kind 0: program request of sector addr[9:0], expected 1 = reject (R6).
    // kind 1: identification read of addr, expected byte (R8, R9).
    localparam logic [25:0] VEC [10] = '{
        {1'b0, 17'd0,     8'd1},
        {1'b0, 17'd63,    8'd1},
        {1'b0, 17'd64,    8'd0},
        {1'b0, 17'd500,   8'd0},
        {1'b0, 17'd959,   8'd0},
        {1'b0, 17'd1023,  8'd0},
        {1'b1, 17'h00002, 8'hFF},
        {1'b1, 17'h1FFF2, 8'hFE},
        {1'b1, 17'h00000, 8'h1F},
        {1'b1, 17'h00001, 8'h5D}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Full sequence; bad_step < 6 corrupts that step's data.
    task automatic do_seq(input logic [16:0] fin_a, input logic [7:0] fin_d, input int bad_step);
        for (int i = 0; i < 6; i++) begin
            do_write(S_ADDR[i], (i == bad_step) ? ~S_DATA[i] : S_DATA[i]);
        end
        do_write(fin_a, fin_d);
    endtask

    task automatic do_prog(input logic [9:0] s, input logic exp_rej, input string tag);
        @(negedge clk);
        prog_req    = 1'b1;
        prog_sector = s;
        @(negedge clk);
        prog_req = 1'b0;
        chk({31'd0, prog_reject}, {31'd0, exp_rej}, tag);
        chk({31'd0, prog_grant}, {31'd0, !exp_rej}, tag);
    endtask

    task automatic do_erase(input logic exp_rej, input string tag);
        @(negedge clk);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        chk({31'd0, erase_reject}, {31'd0, exp_rej}, tag);
        chk({31'd0, erase_grant}, {31'd0, !exp_rej}, tag);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk({24'd0, id_data}, {24'd0, exp}, tag);
    endtask

    task automatic strobe(input logic en, input logic ex);
        @(negedge clk);
        id_enter = en;
        id_exit  = ex;
        @(negedge clk);
        id_enter = 1'b0;
        id_exit  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({31'd0, lock_low}, 32'd0, "R1 lock_low");
        chk({31'd0, lock_high}, 32'd0, "R1 lock_high");
        chk({31'd0, id_active}, 32'd0, "R1 id_active");
        chk({28'd0, prog_grant, prog_reject, erase_grant, erase_reject}, 32'd0, "R1 verdicts");

        // R8 quiet outside identification mode
        do_read(17'h00000, 8'h00, "R8 inactive read");
        chk({31'd0, id_hit}, 32'd0, "R8 inactive hit");
        strobe(1'b1, 1'b0);
        chk({31'd0, id_active}, 32'd1, "R8 enter");
        do_read(17'h00001, 8'h5D, "R8 device code");
        do_read(17'h00002, 8'hFE, "R9 low open");
        do_read(17'h1FFF2, 8'hFE, "R9 high open");
        do_read(17'h00003, 8'h00, "R9 other addr");
        chk({31'd0, id_hit}, 32'd0, "R9 other hit");

        do_erase(1'b0, "R7 erase unlocked");

        // R4 mismatch at step 3, then rest of the attempt
        do_seq(17'h01000, 8'h00, 3);
        chk({31'd0, lock_low}, 32'd0, "R4 mismatch no lock");
        // R5 bad final data, final address outside both regions
        do_seq(17'h01000, 8'h01, 7);
        chk({31'd0, lock_low}, 32'd0, "R5 bad final data");
        do_seq(17'h08000, 8'h00, 7);
        chk({30'd0, lock_high, lock_low}, 32'd0, "R5 middle address");

        // R2 lock low only
        do_seq(17'h01000, 8'h00, 7);
        chk({31'd0, lock_low}, 32'd1, "R2 low locked");
        chk({31'd0, lock_high}, 32'd0, "R2 high untouched");

        for (int i = 0; i < 10; i++) begin
            if (VEC[i][25] == 1'b0) begin
                do_prog(VEC[i][17:8], VEC[i][0], "R6 table program");
            end else begin
                do_read(VEC[i][24:8], VEC[i][7:0], "R9 table read");
            end
        end
        do_erase(1'b1, "R7 erase low locked");

        // R3 lock high as well
        do_seq(17'h1E000, 8'h00, 7);
        chk({31'd0, lock_high}, 32'd1, "R3 high locked");
        chk({31'd0, lock_low}, 32'd1, "R3 low still locked");
        do_prog(10'd960, 1'b1, "R6 high boundary");
        do_prog(10'd1023, 1'b1, "R6 high top");
        do_read(17'h1FFF2, 8'hFF, "R9 high status");

        // R8 exit wins over enter
        strobe(1'b1, 1'b1);
        chk({31'd0, id_active}, 32'd0, "R8 exit priority");
        do_read(17'h00002, 8'h00, "R8 read after exit");

        // R10 locks persist through more traffic
        do_seq(17'h01000, 8'h00, 2);
        do_write(17'h00002, 8'hFE);
        strobe(1'b1, 1'b0);
        chk({30'd0, lock_high, lock_low}, 32'd3, "R10 locks persist");
        do_read(17'h00002, 8'hFF, "R10 low status persists");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule